// File: doc/BRIEF.md
# Halt Mode Power Sequencer

This block sequences a small microcontroller into and out of its deepest sleep mode. When the instruction decoder strobes a halt request, the sequencer opens the two CPU interrupt-mask bits to `10`. It then either stops the oscillator and gates every internal clock (full halt), or leaves the oscillator running and gates only the CPU and peripheral clocks (active halt). A configuration bit selects which of the two. If a wake-capable source is already asserted when the request arrives, the core never goes to sleep and resumes at once.

While fully halted, only a reset request or an interrupt line that is set in the `WAKE_MASK` parameter can wake the core. Any other line is ignored. On a wake, the oscillator is enabled at once. The CPU and peripheral clocks stay gated for a settle window of 256 or 4096 cycles, chosen by a delay-select input that is sampled at the wake edge. When the window ends, a one-cycle resume pulse is issued together with the wake cause. An active-halt wake needs no settle window, because the oscillator never stopped. The current sequencer state is driven out on a status port.

Top module: `halt_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, `seq_state` is 0 (run), `osc_en`, `cpu_clk_en` and `periph_clk_en` are 1, and `resume` and `imask_wr` are 0.
- R2: A `halt_req` in run with `osc_irq_en` = 0 and no wake source active moves `seq_state` to 1 (full halt) at the next edge, with `osc_en`, `cpu_clk_en` and `periph_clk_en` all 0.
- R3: Every `halt_req` accepted in run makes `imask_wr` high for exactly the next cycle, with `imask_val` = 2'b10.
- R4: A `halt_req` with `osc_irq_en` = 1 moves `seq_state` to 3 (active halt), with `osc_en` 1 and both clocks 0. A wake there returns to run at the next edge with a `resume` pulse and no settle window.
- R5: A `halt_req` while a wake source is active keeps `seq_state` at 0 with `osc_en` never dropping, and pulses `resume` in the next cycle.
- R6: In full halt, `irq_req` lines whose `WAKE_MASK` bit is 0 (lines 7..4 by default) have no effect: the state stays 1 and `osc_en` stays 0.
- R7: A wake in full halt moves `seq_state` to 2 (stabilize) at the next edge, with `osc_en` 1 and both clocks still 0.
- R8: Stabilize lasts exactly 256 cycles when `long_dly_sel` was 0 at the wake edge, and 4096 cycles when it was 1. Changing `long_dly_sel` during stabilize has no effect.
- R9: At the end of stabilize, the state returns to 0, the clocks turn on, and `resume` is high for exactly one cycle. `resume_cause` is 1 for a reset-request wake and 0 for an interrupt wake.
- R10: When `rst_wake_req` and a wake-capable interrupt are both active at the wake, `resume_cause` is 1.
- R11: Driving `rst_n` low returns the block to run immediately from any state, with the oscillator and clocks on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-derived clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| halt_req | input | 1 | Halt instruction strobe from the decoder |
| osc_irq_en | input | 1 | 1 selects active halt, 0 selects full halt |
| long_dly_sel | input | 1 | Settle window select: 0 = 256 cycles, 1 = 4096 cycles |
| rst_wake_req | input | 1 | Chip reset request that wakes from halt |
| irq_req | input | N_IRQ | Interrupt request lines |
| osc_en | output | 1 | Oscillator enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| imask_wr | output | 1 | Write strobe for the interrupt-mask bits |
| imask_val | output | 2 | Value written to the mask bits |
| resume | output | 1 | One-cycle pulse when the CPU may run again |
| resume_cause | output | 1 | 1 = fetch reset vector, 0 = service interrupt |
| seq_state | output | 2 | 0 run, 1 full halt, 2 stabilize, 3 active halt |

## Verification
Halt entry is tried three ways: with `osc_irq_en` clear, with it set, and with a wake source already pending. Together these separate the full-halt, active-halt and immediate-resume paths. Wakes are driven by a masked interrupt line, by an unmasked line alone, by the reset request, and by the reset request together with an interrupt. These show the wake filter and the cause priority. The settle window is measured with both delay selects, and once with the select toggled mid-window, to show that the select is sampled at the wake edge. A block reset applied mid-window shows that the async return path works.

// File: rtl/halt_seq_pkg.sv
package halt_seq_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_HALT  = 2'd1,
    ST_STAB  = 2'd2,
    ST_AHALT = 2'd3
  } hs_state_t;

  localparam logic [1:0] MASK_OPEN = 2'b10;

  // settle window length in cycles for a given select
  function automatic int unsigned settle_len(input logic long_sel,
                                             input int unsigned short_n,
                                             input int unsigned long_n);
    return long_sel ? long_n : short_n;
  endfunction
endpackage

// File: rtl/halt_wake_detect.sv
module halt_wake_detect #(
  parameter int unsigned N_IRQ = 8,
  parameter logic [N_IRQ-1:0] WAKE_MASK = '1
) (
  input  logic [N_IRQ-1:0] irq_req,
  input  logic             rst_req,
  output logic             wake,
  output logic             cause_rst
);
  logic irq_wake;
  assign irq_wake  = |(irq_req & WAKE_MASK);
  assign wake      = irq_wake | rst_req;
  assign cause_rst = rst_req;   // reset wins over a concurrent interrupt
endmodule

// File: rtl/halt_settle_timer.sv
module halt_settle_timer
  import halt_seq_pkg::*;
#(
  parameter int unsigned SHORT_N = 256,
  parameter int unsigned LONG_N  = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic long_sel,
  output logic done
);
  localparam int unsigned CW = $clog2(LONG_N);

  logic [CW-1:0] cnt;
  logic          busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (load) begin
      cnt  <= CW'(settle_len(long_sel, SHORT_N, LONG_N) - 1);
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);

  // R8: the counter never wraps while the window is open
  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0 && !load) |=> busy);
endmodule

// File: rtl/halt_seq.sv
module halt_seq
  import halt_seq_pkg::*;
#(
  parameter int unsigned N_IRQ = 8,
  parameter logic [N_IRQ-1:0] WAKE_MASK = 8'h0F,
  parameter int unsigned SHORT_N = 256,
  parameter int unsigned LONG_N  = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_req,
  input  logic             osc_irq_en,
  input  logic             long_dly_sel,
  input  logic             rst_wake_req,
  input  logic [N_IRQ-1:0] irq_req,
  output logic             osc_en,
  output logic             periph_clk_en,
  output logic             cpu_clk_en,
  output logic             imask_wr,
  output logic [1:0]       imask_val,
  output logic             resume,
  output logic             resume_cause,
  output logic [1:0]       seq_state
);
  hs_state_t state;
  logic wake, wake_rst, settle_done, settle_load;

  halt_wake_detect #(.N_IRQ(N_IRQ), .WAKE_MASK(WAKE_MASK)) u_wake (
    .irq_req  (irq_req),
    .rst_req  (rst_wake_req),
    .wake     (wake),
    .cause_rst(wake_rst)
  );

  assign settle_load = (state == ST_HALT) && wake;

  halt_settle_timer #(.SHORT_N(SHORT_N), .LONG_N(LONG_N)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (settle_load),
    .long_sel(long_dly_sel),
    .done    (settle_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_RUN;
      imask_wr     <= 1'b0;
      resume       <= 1'b0;
      resume_cause <= 1'b0;
    end else begin
      imask_wr <= 1'b0;
      resume   <= 1'b0;
      unique case (state)
        ST_RUN: if (halt_req) begin
          imask_wr <= 1'b1;
          if (wake) begin
            resume       <= 1'b1;
            resume_cause <= wake_rst;
          end else if (osc_irq_en) begin
            state <= ST_AHALT;
          end else begin
            state <= ST_HALT;
          end
        end
        ST_HALT: if (wake) begin
          state        <= ST_STAB;
          resume_cause <= wake_rst;
        end
        ST_STAB: if (settle_done) begin
          state  <= ST_RUN;
          resume <= 1'b1;
        end
        ST_AHALT: if (wake) begin
          state        <= ST_RUN;
          resume       <= 1'b1;
          resume_cause <= wake_rst;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign osc_en        = (state != ST_HALT);
  assign cpu_clk_en    = (state == ST_RUN);
  assign periph_clk_en = (state == ST_RUN);
  assign imask_val     = MASK_OPEN;
  assign seq_state     = state;

  assert_enter_halt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && halt_req && !osc_irq_en && !wake) |=> (!osc_en && !cpu_clk_en));
  assert_mask_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && halt_req) |=> (imask_wr && imask_val == 2'b10));
  assert_active_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && halt_req && osc_irq_en && !wake) |=> (osc_en && !cpu_clk_en));
  assert_pending_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && halt_req && wake) |=> (osc_en && resume));
  assert_ignore_lines_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT && !wake) |=> (state == ST_HALT));
  assert_osc_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    settle_load |=> (osc_en && !cpu_clk_en && !periph_clk_en));
  assert_resume_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume);
  assert_rst_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT && rst_wake_req) |=> resume_cause);
endmodule

// File: tb/halt_seq_bench.sv
module halt_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       halt_req = 1'b0, osc_irq_en = 1'b0, long_dly_sel = 1'b0, rst_wake_req = 1'b0;
  logic [7:0] irq_req = '0;
  logic       osc_en, periph_clk_en, cpu_clk_en, imask_wr, resume, resume_cause;
  logic [1:0] imask_val, seq_state;

  int total = 0, bad = 0;

  always #4 clk = ~clk;   // 125 MHz

  halt_seq u_halt_seq (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .osc_irq_en(osc_irq_en),
    .long_dly_sel(long_dly_sel), .rst_wake_req(rst_wake_req), .irq_req(irq_req),
    .osc_en(osc_en), .periph_clk_en(periph_clk_en), .cpu_clk_en(cpu_clk_en),
    .imask_wr(imask_wr), .imask_val(imask_val), .resume(resume),
    .resume_cause(resume_cause), .seq_state(seq_state)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic int exp_window(input logic sel);
    return sel ? 4096 : 256;
  endfunction

  task automatic enter_full_halt();
    osc_irq_en = 1'b0; halt_req = 1'b1; tick(); halt_req = 1'b0;
  endtask

  // counts cycles spent in stabilize, starting from the first one
  task automatic measure_stab(output int n);
    n = 0;
    while (seq_state == 2'd2 && n < 5000) begin
      n++; tick();
    end
  endtask

  task automatic t_reset();
    chk("R1 state", seq_state, 0);
    chk("R1 clocks", {osc_en, cpu_clk_en, periph_clk_en}, 3'b111);
    chk("R1 resume/imask", {resume, imask_wr}, 0);
  endtask

  task automatic t_full_halt_irq_short();
    int n;
    enter_full_halt();
    chk("R2 state", seq_state, 1);
    chk("R2 gates", {osc_en, cpu_clk_en, periph_clk_en}, 0);
    chk("R3 imask_wr", imask_wr, 1);
    chk("R3 imask_val", imask_val, 2);
    tick();
    chk("R3 imask_wr one cycle", imask_wr, 0);
    irq_req = 8'hF0;                       // non-wake lines only
    repeat (3) tick();
    chk("R6 state", seq_state, 1);
    chk("R6 osc", osc_en, 0);
    irq_req = 8'h02; long_dly_sel = 1'b0;
    tick(); irq_req = '0;
    chk("R7 state", seq_state, 2);
    chk("R7 gates", {osc_en, cpu_clk_en, periph_clk_en}, 3'b100);
    measure_stab(n);
    chk("R8 short window", n, exp_window(1'b0));
    chk("R9 resume", resume, 1);
    chk("R9 cause irq", resume_cause, 0);
    chk("R9 clocks on", {cpu_clk_en, periph_clk_en}, 2'b11);
    tick();
    chk("R9 resume one cycle", resume, 0);
  endtask

  task automatic t_full_halt_rst_long();
    int n;
    enter_full_halt();
    rst_wake_req = 1'b1; irq_req = 8'h01; long_dly_sel = 1'b1;
    tick(); rst_wake_req = 1'b0; irq_req = '0;
    long_dly_sel = 1'b0;                   // toggled mid-window: no effect
    measure_stab(n);
    chk("R8 long window", n, exp_window(1'b1));
    chk("R10 cause reset", resume_cause, 1);
    chk("R9 resume", resume, 1);
    tick();
  endtask

  task automatic t_active_halt();
    osc_irq_en = 1'b1; halt_req = 1'b1; tick(); halt_req = 1'b0;
    chk("R4 state", seq_state, 3);
    chk("R4 gates", {osc_en, cpu_clk_en, periph_clk_en}, 3'b100);
    chk("R3 imask_wr", imask_wr, 1);
    irq_req = 8'h08; tick(); irq_req = '0;
    chk("R4 back to run", seq_state, 0);
    chk("R4 resume", resume, 1);
    osc_irq_en = 1'b0;
    tick();
  endtask

  task automatic t_pending();
    irq_req = 8'h04; halt_req = 1'b1; tick(); halt_req = 1'b0; irq_req = '0;
    chk("R5 state", seq_state, 0);
    chk("R5 osc", osc_en, 1);
    chk("R5 resume", resume, 1);
    chk("R5 cause", resume_cause, 0);
    tick();
  endtask

  task automatic t_async_reset();
    enter_full_halt();
    irq_req = 8'h01; tick(); irq_req = '0;
    repeat (10) tick();
    chk("R11 in stab", seq_state, 2);
    rst_n = 1'b0; #1;
    chk("R11 state", seq_state, 0);
    chk("R11 clocks", {osc_en, cpu_clk_en, periph_clk_en}, 3'b111);
    tick(); rst_n = 1'b1; tick();
  endtask

  initial begin
    #2;
    t_reset();
    repeat (2) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_full_halt_irq_short();
    t_full_halt_rst_long();
    t_active_halt();
    t_pending();
    t_async_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule